// File: doc/BRIEF.md
# Fractional Bit-Clock Generator and Edge Tracker

This block produces a serial bit clock from a fast system clock, or follows a bit clock that arrives from outside. In generate mode a 32-bit phase accumulator adds a programmable increment on every system clock, and the bit clock is the top bit of that accumulator. The output frequency is therefore the system clock frequency times the increment over 2^32. One-cycle rise and fall strobes mark each generated edge, and the output-enable is raised so the pad drives the clock.

An increment of zero switches the block to receive mode. The pad is released and the external bit clock passes through a two-stage synchronizer. A change of level is accepted only after a programmable number of consecutive samples agree. The accepted edge is then announced as a strobe, delayed by a fixed compensation plus a signed tuning value, so that downstream logic sees the edge at a chosen point after it really happened. Frame-sync handling lives elsewhere.

Top module: `bclk_tracker`

## Requirements
- R1: While reset is high, and on the first cycle after it, `bclk_out`, `bclk_oe`, `rise_stb` and `fall_stb` are all 0 and the accumulator is 0.
- R2: One clock after any cycle with a nonzero `incr_n`, `bclk_oe` is 1; one clock after a cycle with `incr_n` = 0, it is 0.
- R3: In generate mode the accumulator adds `incr_n` (mod 2^32) every clock, and `bclk_out` equals the accumulator's most significant bit as it stood one clock earlier, giving a rate of f_clk * `incr_n` / 2^32.
- R4: In generate mode `rise_stb` is 1 for exactly the cycles in which `bclk_out` has just gone from 0 to 1, and `fall_stb` for exactly those in which it has just gone from 1 to 0.
- R5: A new `incr_n` is used from the next clock on without clearing the accumulator, so the phase carries across the change, including a pass through receive mode.
- R6: In receive mode (`incr_n` = 0) `bclk_out` is held at 0 whatever `bclk_in` does.
- R7: In receive mode a level change on `bclk_in` is accepted only after `samp_cnt` consecutive synchronized samples differ from the accepted level; `samp_cnt` = 0 acts as 1, and a pulse shorter than that produces no strobe.
- R8: An accepted receive edge raises its strobe D clocks after acceptance, where D = `samp_cnt` + 3 + `samp_delta` (two's complement); measured from a `bclk_in` change, the strobe appears 2 + max(`samp_cnt`,1) + D clocks later.
- R9: When `samp_cnt` + 3 + `samp_delta` is negative or zero, D is 0 and the strobe appears in the same clock the edge is accepted.
- R10: Only one delayed edge is held; an edge accepted while another is still waiting replaces it, and the older one never produces a strobe.
- R11: An accepted rising edge of `bclk_in` yields `rise_stb`, an accepted falling edge yields `fall_stb`, each for one clock.
- R12: `rise_stb` and `fall_stb` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| incr_n | input | 32 | Phase increment per clock; 0 selects receive mode |
| samp_cnt | input | 16 | Number of agreeing samples needed to accept a received edge |
| samp_delta | input | 16 | Signed tuning added to the received-edge delay |
| bclk_in | input | 1 | External bit clock (receive mode) |
| bclk_out | output | 1 | Generated bit clock |
| bclk_oe | output | 1 | High while the block drives the bit clock |
| rise_stb | output | 1 | One-cycle marker of a bit-clock rising edge |
| fall_stb | output | 1 | One-cycle marker of a bit-clock falling edge |

## Verification
The generator is run with an increment of exactly half the range, with all ones, and with several random increments switched back to back, so that toggling every cycle, wrap-around every cycle and phase carry-over across increment changes are each distinguished against a bench accumulator; a long run with a power-of-two increment checks the edge rate. The receiver is driven with single clean edges under random and directed sample counts and deltas, separating the debounce length, the compensation term and the clamp at zero. Pulses one sample short of acceptance show that the debounce rejects them, and a second edge arriving during a long delay shows whether the older pending edge is replaced or leaks out.

// File: rtl/bclk_pkg.sv
package bclk_pkg;
  // Pair of one-cycle edge markers carried between the sub-blocks.
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_pair_t;
endpackage

// File: rtl/bclk_phase_gen.sv
module bclk_phase_gen
  import bclk_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] incr,
  output logic             level,
  output logic             oe,
  output edge_pair_t       stb
);
  localparam int TOP = ACC_W - 1;

  logic [ACC_W-1:0] acc;
  logic             gen_on;

  assign gen_on = |incr;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      level <= 1'b0;
      oe    <= 1'b0;
      stb   <= '0;
    end else begin
      // Zero increment simply holds the phase.
      acc <= acc + incr;
      oe  <= gen_on;
      if (gen_on) begin
        level    <= acc[TOP];
        stb.rise <= acc[TOP] & ~level;
        stb.fall <= ~acc[TOP] & level;
      end else begin
        level <= 1'b0;
        stb   <= '0;
      end
    end
  end
endmodule

// File: rtl/bclk_rx_filter.sv
module bclk_rx_filter #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             din,
  input  logic [CNT_W-1:0] samp,
  output logic             accept,
  output logic             accept_rise
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   synced;
  logic                   lvl;
  logic [CNT_W-1:0]       run_cnt;
  logic [CNT_W:0]         run_next;
  logic [CNT_W:0]         need;
  logic                   differs;

  // Synchronizer chain, depth set by parameter.
  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      end
    end
  endgenerate

  assign synced      = sync_q[SYNC_STAGES-1];
  assign differs     = synced ^ lvl;
  assign need        = (samp == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, samp};
  assign run_next    = {1'b0, run_cnt} + 1'b1;
  assign accept      = ~hold & differs & (run_next >= need);
  assign accept_rise = synced;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl     <= 1'b0;
      run_cnt <= '0;
    end else if (hold) begin
      lvl     <= synced;
      run_cnt <= '0;
    end else if (!differs) begin
      run_cnt <= '0;
    end else if (accept) begin
      lvl     <= synced;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_next[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/bclk_edge_delay.sv
module bclk_edge_delay
  import bclk_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int COMP  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    hold,
  input  logic                    launch,
  input  logic                    launch_rise,
  input  logic [CNT_W-1:0]        samp,
  input  logic signed [CNT_W-1:0] delta,
  output edge_pair_t              stb
);
  localparam int DW = CNT_W + 2;
  localparam logic signed [DW-1:0] COMP_S = DW'(COMP);

  logic signed [DW-1:0] samp_s;
  logic signed [DW-1:0] delta_s;
  logic signed [DW-1:0] total;
  logic [DW-2:0]        dly;
  logic [DW-2:0]        dcnt;
  logic                 pend;
  logic                 pend_rise;

  assign samp_s  = $signed({2'b00, samp});
  assign delta_s = $signed({{2{delta[CNT_W-1]}}, delta});
  assign total   = samp_s + delta_s + COMP_S;
  // Negative totals clamp to an immediate strobe.
  assign dly     = total[DW-1] ? '0 : total[DW-2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      pend_rise <= 1'b0;
      dcnt      <= '0;
      stb       <= '0;
    end else begin
      stb <= '0;
      if (hold) begin
        pend <= 1'b0;
      end else if (launch) begin
        // A fresh edge always displaces a waiting one.
        if (dly == '0) begin
          stb.rise <= launch_rise;
          stb.fall <= ~launch_rise;
          pend     <= 1'b0;
        end else begin
          pend      <= 1'b1;
          pend_rise <= launch_rise;
          dcnt      <= dly - 1'b1;
        end
      end else if (pend) begin
        if (dcnt == '0) begin
          stb.rise <= pend_rise;
          stb.fall <= ~pend_rise;
          pend     <= 1'b0;
        end else begin
          dcnt <= dcnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bclk_tracker.sv
module bclk_tracker
  import bclk_pkg::*;
#(
  parameter int ACC_W       = 32,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ACC_W-1:0]        incr_n,
  input  logic [CNT_W-1:0]        samp_cnt,
  input  logic signed [CNT_W-1:0] samp_delta,
  input  logic                    bclk_in,
  output logic                    bclk_out,
  output logic                    bclk_oe,
  output logic                    rise_stb,
  output logic                    fall_stb
);
  // Synchronizer depth plus one cycle of uncertainty.
  localparam int COMP = SYNC_STAGES + 1;

  logic       gen_mode;
  logic       acc_edge;
  logic       acc_edge_rise;
  edge_pair_t gen_stb;
  edge_pair_t rx_stb;

  assign gen_mode = |incr_n;

  bclk_phase_gen #(.ACC_W(ACC_W)) u_gen (
    .clk   (clk),
    .rst   (rst),
    .incr  (incr_n),
    .level (bclk_out),
    .oe    (bclk_oe),
    .stb   (gen_stb)
  );

  bclk_rx_filter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_filt (
    .clk         (clk),
    .rst         (rst),
    .hold        (gen_mode),
    .din         (bclk_in),
    .samp        (samp_cnt),
    .accept      (acc_edge),
    .accept_rise (acc_edge_rise)
  );

  bclk_edge_delay #(.CNT_W(CNT_W), .COMP(COMP)) u_dly (
    .clk         (clk),
    .rst         (rst),
    .hold        (gen_mode),
    .launch      (acc_edge),
    .launch_rise (acc_edge_rise),
    .samp        (samp_cnt),
    .delta       (samp_delta),
    .stb         (rx_stb)
  );

  // Each source is cleared while the other mode is active.
  assign rise_stb = gen_stb.rise | rx_stb.rise;
  assign fall_stb = gen_stb.fall | rx_stb.fall;
endmodule

// File: rtl/bclk_tracker_chk.sv
module bclk_tracker_chk #(
  parameter int ACC_W = 32,
  parameter int CNT_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic [ACC_W-1:0]        incr_n,
  input logic [CNT_W-1:0]        samp_cnt,
  input logic signed [CNT_W-1:0] samp_delta,
  input logic                    bclk_in,
  input logic                    bclk_out,
  input logic                    bclk_oe,
  input logic                    rise_stb,
  input logic                    fall_stb
);
  assert_oe_on_R2: assert property (@(posedge clk) disable iff (rst)
    (incr_n != '0) |=> bclk_oe);

  assert_rx_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (incr_n == '0) |=> (!bclk_oe && !bclk_out));

  assert_rise_at_edge_R4: assert property (@(posedge clk) disable iff (rst)
    (rise_stb && bclk_oe) |-> (bclk_out && !$past(bclk_out)));

  assert_fall_at_edge_R4: assert property (@(posedge clk) disable iff (rst)
    (fall_stb && bclk_oe) |-> (!bclk_out && $past(bclk_out)));

  assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(rise_stb && fall_stb));
endmodule

bind bclk_tracker bclk_tracker_chk #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_bclk_tracker.sv
module tb_bclk_tracker;
  localparam int CLK_P = 10;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [31:0]        incr_n = '0;
  logic [15:0]        samp_cnt = '0;
  logic signed [15:0] samp_delta = '0;
  logic               bclk_in = 1'b0;
  logic               bclk_out, bclk_oe, rise_stb, fall_stb;

  int checks = 0;
  int fails  = 0;
  int both_hi = 0;
  bit finished = 1'b0;

  // Bench accumulator model (R3, R4)
  logic [31:0] macc = '0;
  logic        mout = 1'b0, mr = 1'b0, mf = 1'b0, moe = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bclk_tracker dut (
    .clk(clk), .rst(rst), .incr_n(incr_n), .samp_cnt(samp_cnt),
    .samp_delta(samp_delta), .bclk_in(bclk_in), .bclk_out(bclk_out),
    .bclk_oe(bclk_oe), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  always @(posedge clk) begin
    if (rst) begin
      macc = '0; mout = 1'b0; mr = 1'b0; mf = 1'b0; moe = 1'b0;
    end else begin
      mr   = (incr_n != 0) && macc[31] && !mout;
      mf   = (incr_n != 0) && !macc[31] && mout;
      mout = (incr_n != 0) ? macc[31] : 1'b0;
      moe  = (incr_n != 0);
      macc = macc + incr_n;
    end
  end

  always @(negedge clk) if (!rst && rise_stb && fall_stb) both_hi++;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rx_latency(input int s, input int d);
    int dl;
    dl = s + 3 + d;
    if (dl < 0) dl = 0;
    return 2 + ((s == 0) ? 1 : s) + dl;
  endfunction

  task automatic run_gen(input logic [31:0] n, input int cycles, input string tag);
    int errs = 0;
    incr_n = n;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (bclk_out !== mout || rise_stb !== mr || fall_stb !== mf || bclk_oe !== moe) begin
        if (errs == 0)
          $display("mismatch %s n=%h cyc=%0d out=%b/%b r=%b/%b f=%b/%b oe=%b/%b", tag, n, i,
                   bclk_out, mout, rise_stb, mr, fall_stb, mf, bclk_oe, moe);
        errs++;
      end
    end
    chk(errs == 0, tag, errs, 0);
  endtask

  task automatic measure(input int s, input int d, input string tag);
    int exp, got = -1;
    bit want_rise, wrong = 1'b0;
    samp_cnt = 16'(s); samp_delta = 16'(d);
    repeat (2) @(negedge clk);
    bclk_in = ~bclk_in;
    want_rise = bclk_in;
    exp = rx_latency(s, d);
    for (int c = 1; c <= exp + 20; c++) begin
      @(negedge clk);
      if (bclk_out || bclk_oe) wrong = 1'b1;
      if ((want_rise && fall_stb) || (!want_rise && rise_stb)) wrong = 1'b1;
      if ((want_rise && rise_stb) || (!want_rise && fall_stb)) begin got = c; break; end
    end
    chk(got == exp, {tag, " latency"}, got, exp);
    chk(!wrong, "R11 R6 polarity and quiet output", wrong, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic glitch(input int s, input int d);
    int seen = 0;
    samp_cnt = 16'(s); samp_delta = 16'(d);
    repeat (2) @(negedge clk);
    bclk_in = ~bclk_in;
    repeat (s - 1) @(negedge clk);
    bclk_in = ~bclk_in;
    for (int c = 0; c < rx_latency(s, d) + 20; c++) begin
      @(negedge clk);
      if (rise_stb || fall_stb) seen++;
    end
    chk(seen == 0, "R7 short pulse rejected", seen, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog all-R actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int rises;
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk({bclk_out, bclk_oe, rise_stb, fall_stb} == 4'b0, "R1 reset outputs",
        {bclk_out, bclk_oe, rise_stb, fall_stb}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({bclk_out, bclk_oe, rise_stb, fall_stb} == 4'b0, "R1 first cycle after reset",
        {bclk_out, bclk_oe, rise_stb, fall_stb}, 0);

    // Generate mode: directed and random increments back to back (R3, R4, R5, R2)
    run_gen(32'h8000_0000, 20, "R3 half-range toggle");
    run_gen(32'hFFFF_FFFF, 50, "R4 all-ones wrap");
    for (int k = 0; k < 4; k++) run_gen($urandom, 200, "R5 random change keeps phase");

    incr_n = 32'h1000_0000;
    rises = 0;
    for (int i = 0; i < 4096; i++) begin
      @(negedge clk);
      if (rise_stb) rises++;
    end
    chk(rises >= 255 && rises <= 257, "R3 edge rate", rises, 256);

    // Receive mode
    incr_n = '0;
    repeat (2) @(negedge clk);
    chk(!bclk_oe && !bclk_out, "R2 R6 released in receive mode", {bclk_oe, bclk_out}, 0);

    measure(3, 0, "R8 nominal");
    measure(3, 0, "R11 falling");
    measure(0, 0, "R7 zero count acts as one");
    measure(2, -10, "R9 clamp");
    measure(4, -7, "R9 zero total");
    measure(1, -32768, "R9 most negative delta");
    for (int k = 0; k < 6; k++)
      measure(int'($urandom_range(8, 1)), int'($urandom_range(24, 0)) - 12, "R8 random");

    glitch(4, 2);
    glitch(6, -9);
    measure(4, 2, "R7 edge after rejected pulse");

    // R10: second edge during a long delay replaces the first
    begin
      int got_r = 0, got_f = -1;
      bit first_rise;
      samp_cnt = 16'd1; samp_delta = 16'sd20;
      repeat (2) @(negedge clk);
      bclk_in = ~bclk_in;
      first_rise = bclk_in;
      for (int c = 1; c <= 60; c++) begin
        @(negedge clk);
        if (c == 5) bclk_in = ~bclk_in;
        if ((first_rise && rise_stb) || (!first_rise && fall_stb)) got_r++;
        if (((first_rise && fall_stb) || (!first_rise && rise_stb)) && got_f < 0) got_f = c;
      end
      chk(got_r == 0, "R10 replaced edge silent", got_r, 0);
      chk(got_f == 32, "R10 newer edge timing", got_f, 32);
    end

    // Back to generate mode: phase carried through receive mode
    run_gen($urandom | 32'h1, 150, "R5 after receive");

    chk(both_hi == 0, "R12 strobes exclusive", both_hi, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule